// File: doc/BRIEF.md
# Bus Tenure Watchdog

This block watches a split-transaction bus for three kinds of hang. An address phase may never be acknowledged. A data phase may never complete. The bus may go quiet for too long. Each watch has its own down-counter, loaded from a programmable limit register, and its own enable bit in a control word.

When the address or data watch expires, the block forces the hung phase to end. It pulses the bus address-acknowledge and transfer-error-acknowledge outputs for one cycle. Every expiry, including one from the inactivity watch, also records a sticky bit in a status word. Software clears that bit by writing 1 to it.

Software reaches the block through a simple single-cycle register port. Writes are taken on the clock edge. Reads are combinational from the word index. The bus side sees only four strobes: address phase start, address phase end, data phase start and data phase end. Arbitration and the datapath stay outside the block.

Each watch runs the same three-state machine:
- TMR_IDLE: not timing.
- TMR_COUNT: the counter is running.
- TMR_EXPIRE: a one-cycle firing state.

Its transitions are:
- IDLE→COUNT on an enabled start.
- COUNT→COUNT on a start, which reloads the counter.
- COUNT→IDLE on a stop or on the enable dropping.
- COUNT→EXPIRE when the counter is at zero and no start or stop is present.
- EXPIRE→COUNT on an enabled start.
- EXPIRE→IDLE otherwise.

Top module: `tenure_watchdog`

## Requirements
- R1: After reset, aack_o and tea_o are low. The control word (index 0) and the status word (index 2) read 0. The identification word (index 1) reads 0x0001.
- R2: Control word at index 0 holds three enables: bit 3 for inactivity, bit 2 for data tenure, bit 1 for address tenure. All its other bits read 0. The limit registers at index 3 (inactivity), 4 (address) and 5 (data) read back the value written.
- R3: With the address watch enabled, let N be the address limit and let edge E0 sample addr_start_i. If no addr_end_i is sampled at any of edges E1..E(N+1), then aack_o and tea_o are both high for exactly one cycle, starting right after edge E(N+1). An addr_end_i sampled at or before E(N+1) suppresses the pulse.
- R4: With only the data watch enabled, a data phase follows the timing of R3, using data_start_i, data_end_i and the data limit. Expiry pulses tea_o only; aack_o stays low.
- R5: Setting the data enable alone also arms the address watch. An unacknowledged address phase then produces the R3 pulse.
- R6: The inactivity watch reloads on every sampled addr_start_i or data_start_i. It expires N+1 edges after the last start, with N being the inactivity limit. Expiry sets status bit 2 only and never drives aack_o or tea_o.
- R7: Status bit 0 (address), bit 1 (data) and bit 2 (inactivity) are set at the clock edge after their watch's pulse cycle. Each stays 1 until cleared.
- R8: Writing the status word with a 1 in a bit position clears that bit. Writing 0 leaves it unchanged.
- R9: If a write-1 clear and a hardware set reach the same status bit on the same edge, the bit ends up 1.
- R10: After expiring, a watch stays quiet until the next start of its own phase.
- R11: The identification word ignores writes.
- R12: Clearing a watch's enable while it counts cancels it with no pulse and no status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_start_i | input | 1 | Address phase begins (one-cycle strobe) |
| addr_end_i | input | 1 | Address phase acknowledged (one-cycle strobe) |
| data_start_i | input | 1 | Data phase begins (one-cycle strobe) |
| data_end_i | input | 1 | Data phase completed (one-cycle strobe) |
| reg_we_i | input | 1 | Register write enable |
| reg_idx_i | input | 3 | Register word index |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| aack_o | output | 1 | Forced address-acknowledge pulse |
| tea_o | output | 1 | Forced transfer-error-acknowledge pulse |

## Verification
The checker assumes that status changes only through a hardware set or an explicit write-1 on the status index. It also assumes the phase strobes are single-cycle pulses sampled on the rising edge. The bench drives every strobe and register access at the falling edge and holds each for exactly one cycle. It keeps the address and data limits small so that a whole tenure fits inside each randomized trial. It starts no new phase until the previous watch has returned to its idle state.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    localparam int IDX_W = 3;
    localparam int DATA_W = 32;

    localparam logic [IDX_W-1:0] IDX_CTRL    = 3'd0;
    localparam logic [IDX_W-1:0] IDX_IDENT   = 3'd1;
    localparam logic [IDX_W-1:0] IDX_STATUS  = 3'd2;
    localparam logic [IDX_W-1:0] IDX_LIM_ACT = 3'd3;
    localparam logic [IDX_W-1:0] IDX_LIM_ADR = 3'd4;
    localparam logic [IDX_W-1:0] IDX_LIM_DAT = 3'd5;

    localparam int CTL_ACT = 3;
    localparam int CTL_DAT = 2;
    localparam int CTL_ADR = 1;

    localparam int ST_ADR = 0;
    localparam int ST_DAT = 1;
    localparam int ST_ACT = 2;
    localparam int ST_W   = 3;

    typedef enum logic [1:0] {
        TMR_IDLE   = 2'd0,
        TMR_COUNT  = 2'd1,
        TMR_EXPIRE = 2'd2
    } tmr_state_t;
endpackage

// File: rtl/wdog_timer.sv
module wdog_timer
    import wdog_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             start,
    input  logic             stop,
    input  logic [CNT_W-1:0] limit,
    output logic             fire
);
    tmr_state_t       st_q, st_d;
    logic [CNT_W-1:0] cnt_q;
    logic             armed_start;

    assign armed_start = en && start;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= TMR_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            TMR_IDLE: begin
                if (armed_start) st_d = TMR_COUNT;
            end
            TMR_COUNT: begin
                if (!en)                 st_d = TMR_IDLE;
                else if (start)          st_d = TMR_COUNT;
                else if (stop)           st_d = TMR_IDLE;
                else if (cnt_q == '0)    st_d = TMR_EXPIRE;
            end
            TMR_EXPIRE: begin
                st_d = armed_start ? TMR_COUNT : TMR_IDLE;
            end
            default: st_d = TMR_IDLE;
        endcase
    end

    // down-counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (armed_start) begin
            cnt_q <= limit;
        end else if (st_q == TMR_COUNT && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // outputs
    always_comb begin
        fire = 1'b0;
        unique case (st_q)
            TMR_IDLE:   fire = 1'b0;
            TMR_COUNT:  fire = 1'b0;
            TMR_EXPIRE: fire = 1'b1;
            default:    fire = 1'b0;
        endcase
    end
endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
    import wdog_pkg::*;
#(
    parameter int          CNT_W   = 16,
    parameter logic [31:0] IDENT   = 32'h0000_0001
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [ST_W-1:0]   hw_set,
    output logic              en_act,
    output logic              en_dat,
    output logic              en_adr,
    output logic [CNT_W-1:0]  lim_act,
    output logic [CNT_W-1:0]  lim_adr,
    output logic [CNT_W-1:0]  lim_dat,
    output logic [ST_W-1:0]   status_q
);
    logic [ST_W-1:0] clr_mask;
    logic            unused_wbits;

    assign unused_wbits = ^wdata;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_act  <= 1'b0;
            en_dat  <= 1'b0;
            en_adr  <= 1'b0;
            lim_act <= '1;
            lim_adr <= '1;
            lim_dat <= '1;
        end else if (we) begin
            unique case (idx)
                IDX_CTRL: begin
                    en_act <= wdata[CTL_ACT];
                    en_dat <= wdata[CTL_DAT];
                    en_adr <= wdata[CTL_ADR];
                end
                IDX_LIM_ACT: lim_act <= wdata[CNT_W-1:0];
                IDX_LIM_ADR: lim_adr <= wdata[CNT_W-1:0];
                IDX_LIM_DAT: lim_dat <= wdata[CNT_W-1:0];
                default: ;
            endcase
        end
    end

    assign clr_mask = (we && idx == IDX_STATUS) ? wdata[ST_W-1:0] : '0;

    // hardware set has priority over software clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= '0;
        end else begin
            status_q <= (status_q & ~clr_mask) | hw_set;
        end
    end

    always_comb begin
        rdata = '0;
        unique case (idx)
            IDX_CTRL: begin
                rdata[CTL_ACT] = en_act;
                rdata[CTL_DAT] = en_dat;
                rdata[CTL_ADR] = en_adr;
            end
            IDX_IDENT:   rdata = IDENT;
            IDX_STATUS:  rdata[ST_W-1:0] = status_q;
            IDX_LIM_ACT: rdata[CNT_W-1:0] = lim_act;
            IDX_LIM_ADR: rdata[CNT_W-1:0] = lim_adr;
            IDX_LIM_DAT: rdata[CNT_W-1:0] = lim_dat;
            default:     rdata = '0;
        endcase
    end
endmodule

// File: rtl/tenure_watchdog.sv
module tenure_watchdog
    import wdog_pkg::*;
#(
    parameter int          CNT_W = 16,
    parameter logic [31:0] IDENT = 32'h0000_0001
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        addr_start_i,
    input  logic        addr_end_i,
    input  logic        data_start_i,
    input  logic        data_end_i,
    input  logic        reg_we_i,
    input  logic [2:0]  reg_idx_i,
    input  logic [31:0] reg_wdata_i,
    output logic [31:0] reg_rdata_o,
    output logic        aack_o,
    output logic        tea_o
);
    logic             en_act, en_dat, en_adr;
    logic [CNT_W-1:0] lim_act, lim_adr, lim_dat;
    logic [ST_W-1:0]  status_q;
    logic [ST_W-1:0]  hw_set;
    logic             fire_act, fire_adr, fire_dat;

    wdog_regs #(.CNT_W(CNT_W), .IDENT(IDENT)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (reg_we_i),
        .idx      (reg_idx_i),
        .wdata    (reg_wdata_i),
        .rdata    (reg_rdata_o),
        .hw_set   (hw_set),
        .en_act   (en_act),
        .en_dat   (en_dat),
        .en_adr   (en_adr),
        .lim_act  (lim_act),
        .lim_adr  (lim_adr),
        .lim_dat  (lim_dat),
        .status_q (status_q)
    );

    // inactivity: reloaded by any phase start, never stopped
    wdog_timer #(.CNT_W(CNT_W)) u_act (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en_act),
        .start (addr_start_i | data_start_i),
        .stop  (1'b0),
        .limit (lim_act),
        .fire  (fire_act)
    );

    // address tenure: also armed by the data enable
    wdog_timer #(.CNT_W(CNT_W)) u_adr (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en_adr | en_dat),
        .start (addr_start_i),
        .stop  (addr_end_i),
        .limit (lim_adr),
        .fire  (fire_adr)
    );

    wdog_timer #(.CNT_W(CNT_W)) u_dat (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en_dat),
        .start (data_start_i),
        .stop  (data_end_i),
        .limit (lim_dat),
        .fire  (fire_dat)
    );

    always_comb begin
        hw_set         = '0;
        hw_set[ST_ADR] = fire_adr;
        hw_set[ST_DAT] = fire_dat;
        hw_set[ST_ACT] = fire_act;
    end

    assign aack_o = fire_adr;
    assign tea_o  = fire_adr | fire_dat;
endmodule

// File: rtl/tenure_watchdog_chk.sv
module tenure_watchdog_chk
    import wdog_pkg::*;
#(
    parameter logic [31:0] IDENT = 32'h0000_0001
) (
    input logic        clk,
    input logic        rst_n,
    input logic        aack_o,
    input logic        tea_o,
    input logic        reg_we_i,
    input logic [2:0]  reg_idx_i,
    input logic [31:0] reg_wdata_i,
    input logic [31:0] reg_rdata_o,
    input logic [2:0]  status_q
);
    logic wr_stat;
    assign wr_stat = reg_we_i && (reg_idx_i == IDX_STATUS);

    // R3
    aack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        aack_o |=> !aack_o);

    // R3
    aack_with_tea_chk: assert property (@(posedge clk) disable iff (!rst_n)
        aack_o |-> tea_o);

    // R7
    tea_records_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tea_o |=> (status_q[ST_ADR] || status_q[ST_DAT]));

    // R7
    adr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q[ST_ADR] && !(wr_stat && reg_wdata_i[ST_ADR])) |=> status_q[ST_ADR]);

    // R7
    dat_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q[ST_DAT] && !(wr_stat && reg_wdata_i[ST_DAT])) |=> status_q[ST_DAT]);

    // R7
    act_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q[ST_ACT] && !(wr_stat && reg_wdata_i[ST_ACT])) |=> status_q[ST_ACT]);

    // R11
    ident_const_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_idx_i == IDX_IDENT) |-> (reg_rdata_o == IDENT));

    // R2
    ctrl_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_idx_i == IDX_CTRL) |-> ((reg_rdata_o & ~32'h0000_000E) == 32'h0));
endmodule

bind tenure_watchdog tenure_watchdog_chk #(.IDENT(IDENT)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .aack_o      (aack_o),
    .tea_o       (tea_o),
    .reg_we_i    (reg_we_i),
    .reg_idx_i   (reg_idx_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .status_q    (status_q)
);

// File: tb/tenure_watchdog_bench.sv
`timescale 1ns/1ps
module tenure_watchdog_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        addr_start_i = 1'b0, addr_end_i = 1'b0;
    logic        data_start_i = 1'b0, data_end_i = 1'b0;
    logic        reg_we_i = 1'b0;
    logic [2:0]  reg_idx_i = 3'd0;
    logic [31:0] reg_wdata_i = 32'd0;
    logic [31:0] reg_rdata_o;
    logic        aack_o, tea_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    tenure_watchdog u_tenure_watchdog (
        .clk(clk), .rst_n(rst_n),
        .addr_start_i(addr_start_i), .addr_end_i(addr_end_i),
        .data_start_i(data_start_i), .data_end_i(data_end_i),
        .reg_we_i(reg_we_i), .reg_idx_i(reg_idx_i), .reg_wdata_i(reg_wdata_i),
        .reg_rdata_o(reg_rdata_o), .aack_o(aack_o), .tea_o(tea_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] idx, input logic [31:0] val);
        @(negedge clk);
        reg_we_i = 1'b1; reg_idx_i = idx; reg_wdata_i = val;
        @(negedge clk);
        reg_we_i = 1'b0; reg_wdata_i = 32'd0;
    endtask

    task automatic rd(input logic [2:0] idx, output logic [31:0] val);
        @(negedge clk);
        reg_idx_i = idx;
        #1 val = reg_rdata_o;
    endtask

    // expected firing of a tenure watch: end sampled at edge k (0 = never)
    function automatic bit exp_fire(input int n, input int k);
        return (k == 0) || (k > n + 1);
    endfunction

    // one tenure; is_data selects the phase; checks aack/tea every cycle
    task automatic tenure(input bit is_data, input int n, input int k, input string req);
        bit f;
        f = exp_fire(n, k);
        @(negedge clk);
        if (is_data) data_start_i = 1'b1; else addr_start_i = 1'b1;
        @(negedge clk);
        addr_start_i = 1'b0; data_start_i = 1'b0;
        if (is_data) data_end_i = (k == 1); else addr_end_i = (k == 1);
        for (int c = 1; c <= n + 3; c++) begin
            @(negedge clk);
            check({req, " tea"}, {31'd0, tea_o}, {31'd0, f && (c == n + 1)});
            check({req, " aack"}, {31'd0, aack_o}, {31'd0, !is_data && f && (c == n + 1)});
            if (is_data) data_end_i = (k == c + 1); else addr_end_i = (k == c + 1);
        end
        addr_end_i = 1'b0; data_end_i = 1'b0;
    endtask

    initial begin
        logic [31:0] v;
        bit saw;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(3'd0, v); check("R1 ctrl", v, 32'd0);
        rd(3'd2, v); check("R1 status", v, 32'd0);
        rd(3'd1, v); check("R1 ident", v, 32'h1);
        check("R1 aack", {31'd0, aack_o}, 32'd0);
        check("R1 tea", {31'd0, tea_o}, 32'd0);

        // R2 register map
        wr(3'd0, 32'hFFFF_FFF1); rd(3'd0, v); check("R2 ctrl mask", v, 32'h0);
        wr(3'd0, 32'h0000_000E); rd(3'd0, v); check("R2 ctrl enables", v, 32'hE);
        wr(3'd0, 32'h0);
        wr(3'd3, 32'h1234); rd(3'd3, v); check("R2 lim act", v, 32'h1234);
        wr(3'd4, 32'h00A5); rd(3'd4, v); check("R2 lim adr", v, 32'h00A5);
        wr(3'd5, 32'h0F0F); rd(3'd5, v); check("R2 lim dat", v, 32'h0F0F);

        // R11 ident ignores writes
        wr(3'd1, 32'hFFFF_FFFF); rd(3'd1, v); check("R11 ident", v, 32'h1);

        // R3 directed: limit 0 and limit 4, never acknowledged
        wr(3'd0, 32'h2); wr(3'd4, 32'd0);
        tenure(1'b0, 0, 0, "R3 lim0");
        rd(3'd2, v); check("R7 adr bit", v, 32'h1);
        wr(3'd2, 32'h0); rd(3'd2, v); check("R8 write0 keeps", v, 32'h1);
        wr(3'd2, 32'h1); rd(3'd2, v); check("R8 clear", v, 32'h0);
        wr(3'd4, 32'd4);
        tenure(1'b0, 4, 5, "R3 end at limit+1");
        rd(3'd2, v); check("R3 suppressed status", v, 32'h0);

        // R10 quiet after firing
        tenure(1'b0, 4, 0, "R10 fire");
        saw = 1'b0;
        repeat (12) begin @(negedge clk); if (aack_o || tea_o) saw = 1'b1; end
        check("R10 quiet", {31'd0, saw}, 32'd0);
        wr(3'd2, 32'h7);

        // R5 data enable arms address watch
        wr(3'd0, 32'h4); wr(3'd4, 32'd2);
        tenure(1'b0, 2, 0, "R5");
        rd(3'd2, v); check("R5 status", v, 32'h1);
        wr(3'd2, 32'h7);

        // R4 data watch
        wr(3'd5, 32'd3);
        tenure(1'b1, 3, 0, "R4");
        rd(3'd2, v); check("R4 status", v, 32'h2);
        wr(3'd2, 32'h7);

        // R9 set wins over a coincident clear (address limit 2)
        @(negedge clk); addr_start_i = 1'b1;
        @(negedge clk); addr_start_i = 1'b0;          // after E0
        repeat (3) @(negedge clk);                     // after E3: pulse cycle
        check("R9 pulse", {31'd0, aack_o}, 32'd1);
        reg_we_i = 1'b1; reg_idx_i = 3'd2; reg_wdata_i = 32'h1;
        @(negedge clk);
        reg_we_i = 1'b0; reg_wdata_i = 32'd0;
        rd(3'd2, v); check("R9 set wins", v, 32'h1);
        wr(3'd2, 32'h1); rd(3'd2, v); check("R9 later clear", v, 32'h0);

        // R12 disable while counting
        wr(3'd0, 32'h2); wr(3'd4, 32'd10);
        @(negedge clk); addr_start_i = 1'b1;
        @(negedge clk); addr_start_i = 1'b0;
        wr(3'd0, 32'h0);
        saw = 1'b0;
        repeat (16) begin @(negedge clk); if (aack_o || tea_o) saw = 1'b1; end
        check("R12 no pulse", {31'd0, saw}, 32'd0);
        rd(3'd2, v); check("R12 no status", v, 32'h0);

        // R6 inactivity: restarts keep it quiet, then it fires silently
        wr(3'd3, 32'd5); wr(3'd0, 32'h8);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk); data_start_i = 1'b1;
            @(negedge clk); data_start_i = 1'b0;
            @(negedge clk);
        end
        rd(3'd2, v); check("R6 reload", v, 32'h0);
        saw = 1'b0;
        repeat (10) begin @(negedge clk); if (aack_o || tea_o) saw = 1'b1; end
        check("R6 no bus drive", {31'd0, saw}, 32'd0);
        rd(3'd2, v); check("R6 status", v, 32'h4);
        wr(3'd0, 32'h0); wr(3'd2, 32'h7);

        // R3/R4/R5 randomized tenures
        for (int t = 0; t < 40; t++) begin
            bit is_d;
            int n, k;
            is_d = $urandom_range(0, 1);
            n = $urandom_range(0, 5);
            k = $urandom_range(0, n + 3);
            if (is_d) wr(3'd0, 32'h4);
            else wr(3'd0, ($urandom_range(0, 1) != 0) ? 32'h2 : 32'h4);
            wr(is_d ? 3'd5 : 3'd4, n);
            tenure(is_d, n, k, is_d ? "R4 rand" : "R3 rand");
            rd(3'd2, v);
            check("R7 rand status", v, exp_fire(n, k) ? (is_d ? 32'h2 : 32'h1) : 32'h0);
            wr(3'd2, 32'h7);
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule